// File: doc/BRIEF.md
# Serial Successive-Approximation ADC Front End

This block is the digital half of a four-channel successive-approximation converter whose serial clock also paces the conversion. The block runs on a fast local clock and oversamples the serial clock, chip select and data-in lines. While chip select is low it waits for a start bit on the data line. It then collects a control byte, decodes from it the analog input pair and the coding of the result, and flags the acquisition window to the track-and-hold. If the control byte requests external-clock conversion, the block raises a strobe for one serial period. It then resolves one result bit on each of the following falling serial edges.

Each decision comes from a comparator input that sits outside the block. The block publishes the trial code that drives the external DAC, and it updates that code after each decision in binary-search order. Each decided bit goes out on the data-out line on the same falling edge, MSB first. Two extra comparator samples follow the result, and zeros follow those until chip select rises. The data-out and strobe lines each come with an output-enable for the pad driver. Both enables drop whenever chip select is high.

Top module: `adc_sif_top`

## Requirements
- R1: After reset, dout, sstrb, acquire, both output enables, dac_code, mux_pos and mux_neg are all zero.
- R2: dout_oe and sstrb_oe are 1 while cs_n is low and 0 while cs_n is high, so that the pads float when the part is deselected.
- R3: With cs_n low, zeros on din are ignored. The first 1 sampled on a rising sclk edge is the start bit. The next seven rising edges latch, in order: sel[2], sel[1], sel[0], a unipolar flag (1 = straight binary), a single-ended flag (1 = single-ended) and a two-bit clock-mode field.
- R4: acquire rises at the rising sclk edge that latches the unipolar flag and falls at the rising edge that latches the last clock-mode bit, so it spans the final three control bits.
- R5: When the clock-mode field is 11, sstrb is 1 for exactly the one sclk period that begins at the falling edge after the last control bit.
- R6: On each of the next 10 falling sclk edges, one result bit is decided from cmp_hi (1 = input at or above the trial code) and driven on dout, MSB first. For unipolar input the output is straight binary. din is ignored until cs_n rises.
- R7: When the unipolar flag is 0, the MSB driven on dout is the inverse of the comparator decision, which gives two's-complement coding. The trial code still uses the raw decision.
- R8: After the 10 result bits, the next two falling edges drive the raw cmp_hi value as sub-bits. Every later falling edge drives 0.
- R9: At the strobe edge dac_code becomes 1000000000b. Each decision at bit position k writes the decision into bit k and sets bit k-1. dac_code changes only on falling sclk edges.
- R10: With single-ended set, selection codes 001, 101, 010 and 110 put CH0, CH1, CH2 and CH3 on mux_pos (one-hot, bit n = CHn), and mux_neg selects COM (bit 4).
- R11: With single-ended clear, code 001 gives CH0+/CH1-, 010 gives CH2+/CH3-, 101 gives CH1+/CH0- and 110 gives CH3+/CH2-.
- R12: A clock-mode field other than 11 starts no conversion: sstrb stays 0, dout stays 0 and dac_code keeps its value.
- R13: Raising cs_n in the middle of a conversion ends it: dout and sstrb fall to 0. After cs_n goes low again, a new control byte converts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control data in |
| cmp_hi | input | 1 | Comparator result, 1 when the input is at or above dac_code |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Pad enable for dout |
| sstrb | output | 1 | Conversion strobe |
| sstrb_oe | output | 1 | Pad enable for sstrb |
| acquire | output | 1 | Track-and-hold acquisition window |
| dac_code | output | RES_BITS | Trial code for the external DAC |
| mux_pos | output | 4 | One-hot positive input select, CH0..CH3 |
| mux_neg | output | 5 | One-hot negative input select, CH0..CH3 then COM |

## Verification
The bench models the analog side as a fixed level compared against dac_code, so every conversion has a known answer. Levels above and below mid-scale are run in both codings. A level above mid-scale shows whether the trial code keeps a 1 decision. A level below mid-scale in bipolar mode shows whether the MSB inversion reaches dout without corrupting the search. Leading idle zeros before the start bit, and ones held on din during the conversion, check that the strobe and the data sit on the right edges. Each selection code in both input modes checks the channel decode, a non-external clock mode checks that no conversion starts, and an abort followed by a fresh byte checks recovery.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

  localparam int CTRL_BITS = 8;
  localparam int NUM_CH    = 4;
  // received-bit counts (start bit = 1) at which fields complete
  localparam int CNT_UNI   = 4;
  localparam int CNT_SGL   = 5;

  typedef enum logic [2:0] {
    CV_IDLE,
    CV_ARM,
    CV_STRB,
    CV_CONV,
    CV_SUB,
    CV_ZERO
  } cv_state_e;

  typedef struct packed {
    logic [2:0] sel;
    logic       uni;
    logic       sgl;
  } ctrl_cfg_t;

endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/adc_sif_ctrl_rx.sv
module adc_sif_ctrl_rx
  import adc_sif_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_hi,
  input  logic      rise_p,
  input  logic      din,
  input  logic      busy,
  output logic      start_p,
  output logic      acquire,
  output ctrl_cfg_t cfg,
  output logic      cfg_vld
);

  localparam int CNT_W = $clog2(CTRL_BITS);
  localparam int SH_W  = CTRL_BITS - 1;

  logic             rx_on_q, rx_on_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SH_W-1:0]  sh_q, sh_n;
  logic             acq_q, acq_n;
  ctrl_cfg_t        cfg_q, cfg_n;
  logic             vld_q, vld_n;
  logic             start_q, start_n;

  always_comb begin
    rx_on_n = rx_on_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    acq_n   = acq_q;
    cfg_n   = cfg_q;
    vld_n   = vld_q;
    start_n = 1'b0;
    if (cs_hi) begin
      rx_on_n = 1'b0;
      cnt_n   = '0;
      acq_n   = 1'b0;
    end else if (rise_p) begin
      if (!rx_on_q) begin
        if (din && !busy) begin
          rx_on_n = 1'b1;
          cnt_n   = CNT_W'(1);
        end
      end else begin
        sh_n  = {sh_q[SH_W-2:0], din};
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(CNT_UNI)) acq_n = 1'b1;
        if (cnt_q == CNT_W'(CNT_SGL)) begin
          cfg_n.sel = sh_q[3:1];
          cfg_n.uni = sh_q[0];
          cfg_n.sgl = din;
          vld_n     = 1'b1;
        end
        if (cnt_q == CNT_W'(CTRL_BITS-1)) begin
          acq_n   = 1'b0;
          rx_on_n = 1'b0;
          cnt_n   = '0;
          start_n = sh_q[0] & din;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      acq_q   <= 1'b0;
      cfg_q   <= '0;
      vld_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      rx_on_q <= rx_on_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      acq_q   <= acq_n;
      cfg_q   <= cfg_n;
      vld_q   <= vld_n;
      start_q <= start_n;
    end
  end

  assign start_p = start_q;
  assign acquire = acq_q;
  assign cfg     = cfg_q;
  assign cfg_vld = vld_q;

endmodule

// File: rtl/adc_sif_chan_dec.sv
module adc_sif_chan_dec
  import adc_sif_pkg::*;
(
  input  logic [2:0]        sel,
  input  logic              sgl,
  input  logic              vld,
  output logic [NUM_CH-1:0] pos,
  output logic [NUM_CH:0]   neg
);

  // sel[1] picks the channel pair, sel[2] picks which member is positive
  logic       code_ok;
  logic [1:0] base;
  logic [1:0] pos_idx;
  logic [1:0] neg_idx;

  always_comb begin
    code_ok = vld & (sel[1] ^ sel[0]);
    base    = {sel[1], 1'b0};
    pos_idx = base | {1'b0, sel[2]};
    neg_idx = base | {1'b0, ~sel[2]};
    pos     = '0;
    neg     = '0;
    if (code_ok) begin
      pos[pos_idx] = 1'b1;
      if (sgl) neg[NUM_CH] = 1'b1;
      else     neg[neg_idx] = 1'b1;
    end
  end

endmodule

// File: rtl/adc_sif_sar.sv
module adc_sif_sar
  import adc_sif_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int SUB_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_hi,
  input  logic                fall_p,
  input  logic                start_p,
  input  logic                bipolar,
  input  logic                cmp_hi,
  output logic                busy,
  output logic                dout,
  output logic                sstrb,
  output logic [RES_BITS-1:0] trial
);

  localparam int IDX_W = $clog2(RES_BITS);
  localparam int SUB_W = $clog2(SUB_BITS + 1);
  localparam logic [IDX_W-1:0] IDX_MSB = IDX_W'(RES_BITS - 1);

  cv_state_e          st_q, st_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic [SUB_W-1:0]   sub_q, sub_n;
  logic               dout_q, dout_n;
  logic               stb_q, stb_n;
  logic               bip_q, bip_n;
  logic [RES_BITS-1:0] trial_q, trial_n;

  logic [IDX_W-1:0]    cur_idx;
  logic [RES_BITS-1:0] trial_upd;

  always_comb begin
    cur_idx   = (st_q == CV_STRB) ? IDX_MSB : idx_q;
    trial_upd = trial_q;
    trial_upd[cur_idx] = cmp_hi;
    if (cur_idx != '0) trial_upd[cur_idx - 1'b1] = 1'b1;
  end

  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    sub_n   = sub_q;
    dout_n  = dout_q;
    stb_n   = stb_q;
    bip_n   = bip_q;
    trial_n = trial_q;
    if (cs_hi) begin
      st_n   = CV_IDLE;
      dout_n = 1'b0;
      stb_n  = 1'b0;
    end else begin
      if (start_p && st_q == CV_IDLE) begin
        st_n  = CV_ARM;
        bip_n = bipolar;
      end
      if (fall_p) begin
        unique case (st_q)
          CV_ARM: begin
            stb_n   = 1'b1;
            dout_n  = 1'b0;
            trial_n = '0;
            trial_n[RES_BITS-1] = 1'b1;
            st_n    = CV_STRB;
          end
          CV_STRB, CV_CONV: begin
            stb_n   = 1'b0;
            trial_n = trial_upd;
            dout_n  = (cur_idx == IDX_MSB && bip_q) ? ~cmp_hi : cmp_hi;
            if (cur_idx == '0) begin
              st_n  = CV_SUB;
              sub_n = '0;
            end else begin
              idx_n = cur_idx - 1'b1;
              st_n  = CV_CONV;
            end
          end
          CV_SUB: begin
            dout_n = cmp_hi;
            sub_n  = sub_q + 1'b1;
            if (sub_q == SUB_W'(SUB_BITS - 1)) st_n = CV_ZERO;
          end
          CV_ZERO: dout_n = 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CV_IDLE;
      idx_q   <= '0;
      sub_q   <= '0;
      dout_q  <= 1'b0;
      stb_q   <= 1'b0;
      bip_q   <= 1'b0;
      trial_q <= '0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      sub_q   <= sub_n;
      dout_q  <= dout_n;
      stb_q   <= stb_n;
      bip_q   <= bip_n;
      trial_q <= trial_n;
    end
  end

  assign busy  = (st_q != CV_IDLE);
  assign dout  = dout_q;
  assign sstrb = stb_q;
  assign trial = trial_q;

endmodule

// File: rtl/adc_sif_top.sv
module adc_sif_top
  import adc_sif_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int SUB_BITS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                din,
  input  logic                cmp_hi,
  output logic                dout,
  output logic                dout_oe,
  output logic                sstrb,
  output logic                sstrb_oe,
  output logic                acquire,
  output logic [RES_BITS-1:0] dac_code,
  output logic [NUM_CH-1:0]   mux_pos,
  output logic [NUM_CH:0]     mux_neg
);

  // reset: asserted asynchronously, released on clk
  logic [1:0] rst_ff_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff_q <= 2'b00;
    else        rst_ff_q <= {rst_ff_q[0], 1'b1};
  end
  assign rst_sn = rst_ff_q[1];

  // pin synchronisers: {sclk, cs_n, din}
  logic [2:0] pins_s;
  logic       sclk_s, cs_s, din_s;

  adc_sif_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sn),
    .d    ({sclk, cs_n, din}),
    .q    (pins_s)
  );
  assign {sclk_s, cs_s, din_s} = pins_s;

  // serial clock edge detect
  logic sclk_d_q;
  logic rise_p, fall_p;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s;
  end
  assign rise_p = sclk_s & ~sclk_d_q;
  assign fall_p = ~sclk_s & sclk_d_q;

  logic      start_p, busy, cfg_vld;
  ctrl_cfg_t cfg;

  adc_sif_ctrl_rx u_rx (
    .clk    (clk),
    .rst_n  (rst_sn),
    .cs_hi  (cs_s),
    .rise_p (rise_p),
    .din    (din_s),
    .busy   (busy),
    .start_p(start_p),
    .acquire(acquire),
    .cfg    (cfg),
    .cfg_vld(cfg_vld)
  );

  adc_sif_chan_dec u_dec (
    .sel(cfg.sel),
    .sgl(cfg.sgl),
    .vld(cfg_vld),
    .pos(mux_pos),
    .neg(mux_neg)
  );

  adc_sif_sar #(
    .RES_BITS(RES_BITS),
    .SUB_BITS(SUB_BITS)
  ) u_sar (
    .clk    (clk),
    .rst_n  (rst_sn),
    .cs_hi  (cs_s),
    .fall_p (fall_p),
    .start_p(start_p),
    .bipolar(~cfg.uni),
    .cmp_hi (cmp_hi),
    .busy   (busy),
    .dout   (dout),
    .sstrb  (sstrb),
    .trial  (dac_code)
  );

  assign dout_oe  = ~cs_s;
  assign sstrb_oe = ~cs_s;

endmodule

// File: rtl/adc_sif_chk.sv
module adc_sif_chk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_s,
  input logic                fall_p,
  input logic                sstrb,
  input logic                dout,
  input logic                acquire,
  input logic [RES_BITS-1:0] dac_code,
  input logic [3:0]          mux_pos,
  input logic [4:0]          mux_neg
);

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sstrb && fall_p) |=> !sstrb);

  p_quiet_deselect_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!dout && !sstrb));

  p_acq_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(acquire && sstrb));

  p_dac_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_p |=> $stable(dac_code));

  p_strobe_dout_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sstrb |-> !dout);

  p_mux_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(mux_pos) && $onehot0(mux_neg)));

endmodule

bind adc_sif_top adc_sif_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sn),
  .cs_s    (cs_s),
  .fall_p  (fall_p),
  .sstrb   (sstrb),
  .dout    (dout),
  .acquire (acquire),
  .dac_code(dac_code),
  .mux_pos (mux_pos),
  .mux_neg (mux_neg)
);

// File: tb/sim_adc_sif_top.sv
module sim_adc_sif_top;

  logic       clk = 1'b0;
  logic       rst_n, sclk, cs_n, din;
  logic [9:0] v_an;
  logic       cmp_hi;
  logic       dout, dout_oe, sstrb, sstrb_oe, acquire;
  logic [9:0] dac_code;
  logic [3:0] mux_pos;
  logic [4:0] mux_neg;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  logic       fr_dout  [32];
  logic       fr_sstrb [32];
  logic       fr_acq   [32];
  logic [9:0] fr_dac   [32];

  always #4 clk = ~clk;

  assign cmp_hi = (v_an >= dac_code);

  adc_sif_top u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .din     (din),
    .cmp_hi  (cmp_hi),
    .dout    (dout),
    .dout_oe (dout_oe),
    .sstrb   (sstrb),
    .sstrb_oe(sstrb_oe),
    .acquire (acquire),
    .dac_code(dac_code),
    .mux_pos (mux_pos),
    .mux_neg (mux_neg)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one serial period: low half then high half, samples taken just before each edge
  task automatic tick(input logic d, output logic o_dout, output logic o_stb,
                      output logic [9:0] o_dac, output logic o_acq);
    @(negedge clk) din = d;
    repeat (7) @(negedge clk);
    o_dout = dout;
    o_stb  = sstrb;
    o_dac  = dac_code;
    sclk   = 1'b1;
    repeat (8) @(negedge clk);
    o_acq  = acquire;
    sclk   = 1'b0;
  endtask

  task automatic frame(input logic [7:0] ctrl, input int nt, input logic fill);
    for (int i = 0; i < nt; i++)
      tick((i < 8) ? ctrl[7-i] : fill, fr_dout[i], fr_sstrb[i], fr_dac[i], fr_acq[i]);
  endtask

  task automatic idle_ticks(input int n);
    logic a, b, e;
    logic [9:0] c;
    for (int i = 0; i < n; i++) begin
      tick(1'b0, a, b, c, e);
      chk("R3", "idle acquire", {31'b0, e}, 32'd0);
    end
  endtask

  task automatic select_on;
    @(negedge clk) cs_n = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic select_off;
    @(negedge clk) cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic check_word(input string req, input logic [9:0] exp);
    for (int k = 0; k < 10; k++)
      chk(req, $sformatf("result bit %0d", 9 - k), {31'b0, fr_dout[9+k]}, {31'b0, exp[9-k]});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0; v_an = '0;
    repeat (5) @(negedge clk);
    chk("R1", "dout in reset", {31'b0, dout}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1", "dout", {31'b0, dout}, 32'd0);
    chk("R1", "sstrb", {31'b0, sstrb}, 32'd0);
    chk("R1", "acquire", {31'b0, acquire}, 32'd0);
    chk("R1", "dac_code", {22'b0, dac_code}, 32'd0);
    chk("R1", "mux", {23'b0, mux_pos, mux_neg}, 32'd0);
    chk("R2", "oe while deselected", {30'b0, dout_oe, sstrb_oe}, 32'd0);
  endtask

  task automatic t_unipolar;
    logic [9:0] v = 10'h2B5;
    int nstb = 0;
    v_an = v;
    select_on();
    chk("R2", "oe while selected", {30'b0, dout_oe, sstrb_oe}, 32'd3);
    idle_ticks(3);
    frame(8'hDF, 26, 1'b1);            // start, sel 101, unipolar, single-ended, mode 11
    for (int i = 0; i < 26; i++) nstb += fr_sstrb[i];
    chk("R3", "strobe after start bit", {31'b0, fr_sstrb[8]}, 32'd1);
    chk("R5", "strobe period count", nstb, 32'd1);
    chk("R4", "acquire before window", {31'b0, fr_acq[3]}, 32'd0);
    for (int i = 4; i < 7; i++) chk("R4", "acquire in window", {31'b0, fr_acq[i]}, 32'd1);
    chk("R4", "acquire after window", {31'b0, fr_acq[7]}, 32'd0);
    check_word("R6", v);
    chk("R9", "dac at strobe", {22'b0, fr_dac[8]}, 32'h200);
    chk("R9", "dac after MSB", {22'b0, fr_dac[9]}, 32'h300);
    chk("R9", "dac at end", {22'b0, fr_dac[19]}, {22'b0, v});
    chk("R8", "sub-bit 1", {31'b0, fr_dout[19]}, 32'd1);
    chk("R8", "sub-bit 2", {31'b0, fr_dout[20]}, 32'd1);
    for (int i = 21; i < 26; i++) chk("R8", "trailing zero", {31'b0, fr_dout[i]}, 32'd0);
    chk("R10", "mux_pos CH1", {28'b0, mux_pos}, 32'b0010);
    chk("R10", "mux_neg COM", {27'b0, mux_neg}, 32'b10000);
    select_off();
  endtask

  task automatic t_bipolar(input logic [7:0] ctrl, input logic [9:0] v,
                           input logic [3:0] ep, input logic [4:0] en);
    v_an = v;
    select_on();
    idle_ticks(1);
    frame(ctrl, 20, 1'b1);
    chk("R7", "strobe", {31'b0, fr_sstrb[8]}, 32'd1);
    check_word("R7", v ^ 10'h200);
    chk("R7", "dac raw at end", {22'b0, fr_dac[19]}, {22'b0, v});
    chk("R11", "mux_pos", {28'b0, mux_pos}, {28'b0, ep});
    chk("R11", "mux_neg", {27'b0, mux_neg}, {27'b0, en});
    select_off();
  endtask

  task automatic t_decode(input logic [7:0] ctrl, input string req,
                          input logic [3:0] ep, input logic [4:0] en);
    select_on();
    frame(ctrl, 8, 1'b0);
    chk(req, "mux_pos", {28'b0, mux_pos}, {28'b0, ep});
    chk(req, "mux_neg", {27'b0, mux_neg}, {27'b0, en});
    select_off();
  endtask

  task automatic t_mode(input logic [7:0] ctrl);
    logic [9:0] dac0;
    int nstb = 0, ndo = 0;
    v_an = 10'h3FF;
    dac0 = dac_code;
    select_on();
    frame(ctrl, 20, 1'b0);
    for (int i = 0; i < 20; i++) begin
      nstb += fr_sstrb[i];
      ndo  += fr_dout[i];
    end
    chk("R12", "no strobe", nstb, 32'd0);
    chk("R12", "dout stays low", ndo, 32'd0);
    chk("R12", "dac held", {22'b0, dac_code}, {22'b0, dac0});
    select_off();
  endtask

  task automatic t_abort;
    v_an = 10'h155;
    select_on();
    frame(8'hDF, 12, 1'b1);
    @(negedge clk) cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R13", "dout after abort", {31'b0, dout}, 32'd0);
    chk("R13", "sstrb after abort", {31'b0, sstrb}, 32'd0);
    chk("R2", "oe after abort", {30'b0, dout_oe, sstrb_oe}, 32'd0);
    repeat (8) @(negedge clk);
    v_an = 10'h0AA;
    select_on();
    idle_ticks(2);
    frame(8'hDF, 20, 1'b1);
    chk("R13", "strobe after restart", {31'b0, fr_sstrb[8]}, 32'd1);
    check_word("R13", 10'h0AA);
    select_off();
  endtask

  initial begin
    t_reset();
    t_unipolar();
    t_bipolar(8'hD3, 10'h0C4, 4'b0010, 5'b00001);   // diff 101: CH1+ CH0-
    t_bipolar(8'hA3, 10'h3A1, 4'b0100, 5'b01000);   // diff 010: CH2+ CH3-
    t_decode(8'h9F, "R10", 4'b0001, 5'b10000);       // SE 001 -> CH0
    t_decode(8'hAF, "R10", 4'b0100, 5'b10000);       // SE 010 -> CH2
    t_decode(8'hEF, "R10", 4'b1000, 5'b10000);       // SE 110 -> CH3
    t_decode(8'h93, "R11", 4'b0001, 5'b00010);       // diff 001: CH0+ CH1-
    t_decode(8'hE3, "R11", 4'b1000, 5'b00100);       // diff 110: CH3+ CH2-
    t_mode(8'h9E);
    t_mode(8'h9D);
    t_abort();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule